// File: doc/BRIEF.md
# Video Memory Word Write Port

This block is the processor-facing write path into a word-organised video memory of 2^15 sixteen-bit words. Software first writes a control byte and a 15-bit word address. The address is written through two byte registers. Software then streams data bytes into the low and high halves of the addressed word. The block turns each data byte write into one byte-wide write on the memory side. The byte address is the word address times two, plus one for the high half.

After a data write the word address can step forward by itself. The step is 1, 32 or 128 words, which suits row-wise, column-wise or block-wise fills of a tile map. A control bit selects whether the low-byte write or the high-byte write moves the address. Software therefore chooses between filling whole words (the high byte last) and filling only one half of each word in a run. A two-bit remapping field in the control byte is held and driven out for a neighbouring address translator. It does not change the addressing inside this block.

The register bus is a plain select/data/strobe interface. The memory side is registered: the byte address, the data and the write enable show up one clock after the strobe. Writes on consecutive cycles are all accepted.

Top module: `vram_wport`

## Requirements
- R1: After reset, mem_we is 0, remap_mode is 0, the word address is 0, the step is 1 word and the low-byte write is the trigger. A first low data write therefore lands at byte address 0, and the next one lands at byte address 2.
- R2: A control write (reg_sel=0) sets the step from data bits 1:0. Code 0 gives 1 word, code 1 gives 32 words, and codes 2 and 3 both give 128 words.
- R3: Control data bit 7 set makes a high data write (reg_sel=4) advance the address, and low data writes leave it unchanged. Bit 7 clear makes a low data write (reg_sel=3) advance the address, and high data writes leave it unchanged.
- R4: Control data bits 3:2 are stored and driven on remap_mode one cycle after the control write. Their value has no effect on mem_addr.
- R5: An address-low write (reg_sel=1) replaces word address bits 7:0 with the data byte and keeps bits 14:8.
- R6: An address-high write (reg_sel=2) loads word address bits 14:8 from data bits 6:0. Data bit 7 is ignored, and bits 7:0 of the address are kept.
- R7: In the cycle after each data write strobe, mem_we is 1 and mem_wdata equals the written byte. mem_addr is {word address, 0} for a low write and {word address, 1} for a high write. The word address used is the one in effect before any advance caused by that write.
- R8: The address advance wraps modulo 2^15. For example, word 0x7FFF with step 1 goes to word 0, and word 0x7FC0 with step 128 goes to word 0x0040.
- R9: Data writes on consecutive clock cycles are each accepted. Each one uses the address left by the one before.
- R10: A strobe with reg_sel 5, 6 or 7, or any select while reg_we is 0, causes no memory write. It also changes neither the address, the configuration nor remap_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select: 0 control, 1 address low, 2 address high, 3 data low, 4 data high |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| mem_addr | output | 16 | Byte address toward the memory |
| mem_wdata | output | 8 | Byte data toward the memory |
| mem_we | output | 1 | Byte write enable, one cycle per data write |
| remap_mode | output | 2 | Stored remapping field for a neighbouring translator |

## Verification
The hardest case to reach is the address wrapping at the top of the 15-bit space with the large step. It happens only when a data write with the matching trigger lands on a word within 128 of the end. Random address loads rarely hit this, so directed sequences place the address at 0x7FFF and 0x7FC0 before advancing it. The bench also switches the trigger in the middle of a run, so that a non-triggering byte follows a triggering one. Random control, address and data writes on back-to-back cycles then mix all steps, both triggers and unused selects.

// File: rtl/vram_wport_pkg.sv
package vram_wport_pkg;

   typedef enum logic [2:0] {
      SEL_CTRL    = 3'd0,
      SEL_ADDR_LO = 3'd1,
      SEL_ADDR_HI = 3'd2,
      SEL_DATA_LO = 3'd3,
      SEL_DATA_HI = 3'd4
   } vwp_sel_e;

   typedef struct packed {
      logic       hi_trigger;
      logic [1:0] remap;
      logic [1:0] step_code;
   } vwp_cfg_t;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/vwp_ctrl_reg.sv
module vwp_ctrl_reg
   import vram_wport_pkg::*;
#(
   parameter int unsigned ADDR_W        = 15,
   parameter int unsigned STEP_MID_LOG2 = 5,
   parameter int unsigned STEP_BIG_LOG2 = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wdata,
   output vwp_cfg_t          cfg,
   output logic [ADDR_W-1:0] step
);

   localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] STEP_MID = ADDR_W'(1) << STEP_MID_LOG2;
   localparam logic [ADDR_W-1:0] STEP_BIG = ADDR_W'(1) << STEP_BIG_LOG2;

   generate
      if (STEP_BIG_LOG2 >= ADDR_W) begin : g_bad_big
         $error("step exponent exceeds address width");
      end
      if (STEP_MID_LOG2 >= STEP_BIG_LOG2) begin : g_bad_order
         $error("middle step must be smaller than large step");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en) begin
         cfg.hi_trigger <= wdata[7];
         cfg.remap      <= wdata[3:2];
         cfg.step_code  <= wdata[1:0];
      end
   end

   always_comb begin
      unique case (cfg.step_code)
         2'd0:    step = STEP_ONE;
         2'd1:    step = STEP_MID;
         default: step = STEP_BIG;
      endcase
   end

   // R2
   step_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(step) == 1);

   // R4
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg));

endmodule

// File: rtl/vwp_addr_unit.sv
module vwp_addr_unit
   import vram_wport_pkg::*;
#(
   parameter int unsigned ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic              adv,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0] step,
   output logic [ADDR_W-1:0] word_addr
);

   localparam int unsigned HI_W = ADDR_W - BYTE_W;

   generate
      if (ADDR_W <= BYTE_W || HI_W > BYTE_W) begin : g_bad_width
         $error("address width must lie between 9 and 16 bits");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_addr <= '0;
      end else if (ld_lo) begin
         word_addr <= {word_addr[ADDR_W-1:BYTE_W], wdata};
      end else if (ld_hi) begin
         word_addr <= {wdata[HI_W-1:0], word_addr[BYTE_W-1:0]};
      end else if (adv) begin
         word_addr <= word_addr + step;
      end
   end

   // R5
   lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo |=> word_addr[ADDR_W-1:BYTE_W] == $past(word_addr[ADDR_W-1:BYTE_W]));

   // R6
   hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hi |=> word_addr[BYTE_W-1:0] == $past(word_addr[BYTE_W-1:0]));

   // R8
   wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ld_lo && !ld_hi) |=>
         word_addr == ADDR_W'($past(word_addr) + $past(step)));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !ld_lo && !ld_hi) |=> $stable(word_addr));

endmodule

// File: rtl/vwp_byte_steer.sv
module vwp_byte_steer
   import vram_wport_pkg::*;
#(
   parameter int unsigned ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0] word_addr,
   output logic [ADDR_W:0]   mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic              mem_we
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= wr_lo | wr_hi;
         if (wr_lo | wr_hi) begin
            mem_addr  <= {word_addr, wr_hi};
            mem_wdata <= wdata;
         end
      end
   end

   // R7
   lane_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo | wr_hi) |=> mem_we && mem_addr[0] == $past(wr_hi));

   // R7
   word_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo | wr_hi) |=> mem_addr[ADDR_W:1] == $past(word_addr));

endmodule

// File: rtl/vram_wport.sv
module vram_wport
   import vram_wport_pkg::*;
#(
   parameter int unsigned ADDR_W        = 15,
   parameter int unsigned STEP_MID_LOG2 = 5,
   parameter int unsigned STEP_BIG_LOG2 = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_sel,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_we,
   output logic [ADDR_W:0]   mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_we,
   output logic [1:0]        remap_mode
);

   vwp_cfg_t          cfg;
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] word_addr;
   logic              wr_ctrl, ld_lo, ld_hi, wr_lo, wr_hi, adv;

   always_comb begin
      wr_ctrl = reg_we && (reg_sel == SEL_CTRL);
      ld_lo   = reg_we && (reg_sel == SEL_ADDR_LO);
      ld_hi   = reg_we && (reg_sel == SEL_ADDR_HI);
      wr_lo   = reg_we && (reg_sel == SEL_DATA_LO);
      wr_hi   = reg_we && (reg_sel == SEL_DATA_HI);
      adv     = cfg.hi_trigger ? wr_hi : wr_lo;
   end

   assign remap_mode = cfg.remap;

   vwp_ctrl_reg #(
      .ADDR_W(ADDR_W), .STEP_MID_LOG2(STEP_MID_LOG2), .STEP_BIG_LOG2(STEP_BIG_LOG2)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(reg_wdata),
      .cfg(cfg), .step(step)
   );

   vwp_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .ld_lo(ld_lo), .ld_hi(ld_hi), .adv(adv),
      .wdata(reg_wdata), .step(step), .word_addr(word_addr)
   );

   vwp_byte_steer #(.ADDR_W(ADDR_W)) u_steer (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(reg_wdata),
      .word_addr(word_addr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
   );

   // R7
   data_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_wdata == $past(reg_wdata));

   // R10
   no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && (reg_sel == 3'd3 || reg_sel == 3'd4)) |=> !mem_we);

   // R3
   trigger_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 3'd4 && !cfg.hi_trigger) |=> $stable(word_addr));

endmodule

// File: tb/vram_wport_tb.sv
module vram_wport_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  reg_sel;
   logic [7:0]  reg_wdata;
   logic        reg_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_we;
   logic [1:0]  remap_mode;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [14:0] m_addr;
   logic [1:0]  m_step;
   logic        m_hi;
   logic [1:0]  m_remap;

   always #5 clk = ~clk;

   vram_wport u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .remap_mode(remap_mode)
   );

   function automatic logic [14:0] step_of(input logic [1:0] code);
      case (code)
         2'd0:    return 15'd1;
         2'd1:    return 15'd32;
         default: return 15'd128;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one register write, checked at the memory port one cycle later
   task automatic op(input logic we, input logic [2:0] sel, input logic [7:0] d, input string tag);
      logic is_data;
      @(negedge clk);
      reg_we = we; reg_sel = sel; reg_wdata = d;
      @(posedge clk);
      #1;
      is_data = we && (sel == 3'd3 || sel == 3'd4);
      if (is_data)
         check(tag, {mem_we, mem_wdata, mem_addr}, {1'b1, d, m_addr, sel == 3'd4});
      else
         check(tag, {31'd0, mem_we}, 32'd0);
      if (we) begin
         case (sel)
            3'd0: begin m_hi = d[7]; m_remap = d[3:2]; m_step = d[1:0]; end
            3'd1: m_addr[7:0] = d;
            3'd2: m_addr[14:8] = d[6:0];
            3'd3: if (!m_hi) m_addr = m_addr + step_of(m_step);
            3'd4: if (m_hi)  m_addr = m_addr + step_of(m_step);
            default: ;
         endcase
      end
      check({tag, " remap"}, {30'd0, remap_mode}, {30'd0, m_remap});
   endtask

   task automatic set_addr(input logic [14:0] a, input string tag);
      op(1'b1, 3'd2, {1'b0, a[14:8]}, tag);
      op(1'b1, 3'd1, a[7:0], tag);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int unused;
      unused = $urandom(32'd1234);
      rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
      m_addr = '0; m_step = '0; m_hi = 1'b0; m_remap = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 we", {31'd0, mem_we}, 32'd0);
      check("R1 remap", {30'd0, remap_mode}, 32'd0);
      op(1'b1, 3'd3, 8'hA5, "R1");
      op(1'b1, 3'd3, 8'h5A, "R1");
      op(1'b1, 3'd4, 8'h3C, "R1");
      // R5 / R6 address loads
      set_addr(15'h1234, "R5");
      op(1'b1, 3'd3, 8'h11, "R5");
      op(1'b1, 3'd1, 8'h77, "R5");
      op(1'b1, 3'd4, 8'h22, "R5");
      op(1'b1, 3'd2, 8'hFF, "R6");
      op(1'b1, 3'd3, 8'h33, "R6");
      // R2 steps
      op(1'b1, 3'd0, 8'h01, "R2");
      op(1'b1, 3'd3, 8'h01, "R2");
      op(1'b1, 3'd3, 8'h02, "R2");
      op(1'b1, 3'd0, 8'h02, "R2");
      op(1'b1, 3'd3, 8'h03, "R2");
      op(1'b1, 3'd3, 8'h04, "R2");
      op(1'b1, 3'd0, 8'h03, "R2");
      op(1'b1, 3'd3, 8'h05, "R2");
      op(1'b1, 3'd3, 8'h06, "R2");
      // R3 trigger on high byte, then switched back mid-run
      op(1'b1, 3'd0, 8'h80, "R3");
      set_addr(15'h0100, "R3");
      op(1'b1, 3'd3, 8'h10, "R3");
      op(1'b1, 3'd3, 8'h11, "R3");
      op(1'b1, 3'd4, 8'h12, "R3");
      op(1'b1, 3'd4, 8'h13, "R3");
      op(1'b1, 3'd0, 8'h00, "R3");
      op(1'b1, 3'd4, 8'h14, "R3");
      op(1'b1, 3'd3, 8'h15, "R3");
      // R4 remap field stored, no effect on address
      op(1'b1, 3'd0, 8'h0C, "R4");
      op(1'b1, 3'd3, 8'h20, "R4");
      op(1'b1, 3'd0, 8'h04, "R4");
      op(1'b1, 3'd3, 8'h21, "R4");
      // R8 wrap
      op(1'b1, 3'd0, 8'h00, "R8");
      set_addr(15'h7FFF, "R8");
      op(1'b1, 3'd3, 8'h30, "R8");
      op(1'b1, 3'd3, 8'h31, "R8");
      op(1'b1, 3'd0, 8'h02, "R8");
      set_addr(15'h7FC0, "R8");
      op(1'b1, 3'd3, 8'h32, "R8");
      op(1'b1, 3'd3, 8'h33, "R8");
      // R10 ignored strobes
      op(1'b1, 3'd5, 8'hFF, "R10");
      op(1'b1, 3'd6, 8'h8F, "R10");
      op(1'b1, 3'd7, 8'h01, "R10");
      op(1'b0, 3'd3, 8'h44, "R10");
      op(1'b0, 3'd0, 8'h8D, "R10");
      op(1'b0, 3'd1, 8'h00, "R10");
      op(1'b1, 3'd3, 8'h45, "R10");
      // R9 random back-to-back mix
      for (int i = 0; i < 4000; i++) begin
         logic [2:0] s;
         logic [7:0] d;
         logic       w;
         s = 3'($urandom_range(0, 7));
         d = 8'($urandom);
         w = ($urandom_range(0, 9) != 0);
         if (s <= 3'd2 && $urandom_range(0, 2) != 0) s = 3'd3 + 3'($urandom_range(0, 1));
         op(w, s, d, "R9");
      end
      @(negedge clk);
      reg_we = 1'b0;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule